// File: doc/BRIEF.md
# Sound Generator Command/Data Bus Bridge

This block links two host I/O ports, a command port and a data port, to the address/data bus of a sound generator. The host first writes a small command code into the command port. That latched code then decides what every later data-port access does. It can forward a byte into the generator's data register, latch a register address, read the generator back, or do nothing at all.

In the extended variant, selected by a parameter, the command register keeps four bits instead of two. The two upper bits redirect data-port reads to the generator's status byte or to its I/O (joystick) port.

Each host access is registered once. Its chip-side strobe is issued in the following clock and lasts one cycle, so no more than one chip access is ever in flight. Every host read, from either port, returns its byte with a valid pulse two cycles after the read strobe. Data fetched from the generator's data register is also kept in a shadow register that stays visible on a port.

Top module: `sndbus_bridge`

## Requirements
- R1: After reset, all chip strobes, `host_rvalid`, `host_rdata`, `chip_addr` and `shadow_data` are zero, and the command code is 0.
- R2: A command-port write stores bits CW-1..0 of the byte (CW = 4 extended, 2 basic). A command-port read in cycle N gives `host_rvalid` high in cycle N+2, with `host_rdata` equal to the stored bits and every higher bit set to 1.
- R3: With command bits 1..0 equal to 0, or equal to 1 on a write, or equal to 3 on a read, a data-port access makes no chip strobe. A read of this kind returns 0xFF two cycles later.
- R4: With command bits 1..0 equal to 2, a data-port write in cycle N raises `chip_data_wr` for exactly cycle N+1, with `chip_wdata` equal to the written byte.
- R5: With command bits 1..0 equal to 3, a data-port write in cycle N raises `chip_addr_wr` in cycle N+1. From that cycle on, `chip_addr` holds the low 4 bits of the byte.
- R6: With command bits 1..0 equal to 2 (and bits 3..2 clear), a data-port read causes no chip read and returns 0xFF two cycles later.
- R7: With command bits 1..0 equal to 1 (bits 3..2 clear), a data-port read in cycle N raises `chip_rd` in N+1 with `chip_rsel`=0 (data). In N+2, `host_rvalid` is high and both `host_rdata` and `shadow_data` hold the `chip_rdata` value from N+1.
- R8: In the extended variant, a data-port read with command bit 3 set reads `chip_rsel`=2 (I/O port). Otherwise, with bit 2 set, it reads `chip_rsel`=1 (status). Both override bits 1..0 on reads, and the returned byte is `chip_rdata` two cycles after the strobe. Data-port writes decode bits 1..0 only.
- R9: At most one chip strobe is active in any cycle, and each host access produces at most one chip strobe, lasting a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cmd_wr | input | 1 | Host write strobe, command port |
| host_cmd_rd | input | 1 | Host read strobe, command port |
| host_dat_wr | input | 1 | Host write strobe, data port |
| host_dat_rd | input | 1 | Host read strobe, data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read result pulse, two cycles after a read strobe |
| chip_addr_wr | output | 1 | Address write strobe to the generator |
| chip_data_wr | output | 1 | Data write strobe to the generator |
| chip_wdata | output | 8 | Byte sent with chip strobes |
| chip_addr | output | 4 | Latched generator register address |
| chip_rd | output | 1 | Read strobe to the generator |
| chip_rsel | output | 2 | Read source: 0 data, 1 status, 2 I/O port |
| chip_rdata | input | 8 | Generator read bus, sampled in the chip_rd cycle |
| shadow_data | output | 8 | Last byte read from the generator data register |

## Verification
The properties assume that the host raises at most one of its four strobes in any cycle. They also assume that the generator presents `chip_rdata` in the same cycle that `chip_rd` is high. The stimulus issues each host access alone and then leaves three idle cycles. The bench's generator model drives `chip_rdata` combinationally from `chip_rsel`, so both assumptions hold throughout. Command codes are swept across the idle, read, write and address codes, and across the status and port bits, including combinations where the upper bits override a conflicting lower code.

// File: rtl/sndbus_pkg.sv
package sndbus_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_IMM,
    OP_DWR,
    OP_AWR,
    OP_RDAT,
    OP_RSTA,
    OP_RPRT
  } op_e;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_PORT = 2'd2;

  localparam logic [1:0] CODE_IDLE  = 2'd0;
  localparam logic [1:0] CODE_READ  = 2'd1;
  localparam logic [1:0] CODE_WRITE = 2'd2;
  localparam logic [1:0] CODE_ADDR  = 2'd3;
endpackage

// File: rtl/sndbus_cmdreg.sv
module sndbus_cmdreg #(
  parameter int CW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [3:0]    cmd,
  output logic [DW-1:0] readback
);
  logic [CW-1:0] cmd_d, cmd_q;

  always_comb begin
    cmd_d = cmd_q;
    if (wr_en) cmd_d = wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_d;
  end

  generate
    if (CW < 4) begin : g_pad
      assign cmd = {{(4-CW){1'b0}}, cmd_q};
    end else begin : g_full
      assign cmd = cmd_q[3:0];
    end
  endgenerate

  assign readback = {{(DW-CW){1'b1}}, cmd_q};
endmodule

// File: rtl/sndbus_decode.sv
module sndbus_decode
  import sndbus_pkg::*;
#(
  parameter int DW = 8,
  parameter bit EXT_CMD = 1'b1
) (
  input  logic [3:0]    cmd,
  input  logic [DW-1:0] cmd_rb,
  input  logic          cmd_rd,
  input  logic          dat_wr,
  input  logic          dat_rd,
  output op_e           op,
  output logic [DW-1:0] imm
);
  logic port_sel, stat_sel;

  assign port_sel = EXT_CMD && cmd[3];
  assign stat_sel = EXT_CMD && cmd[2];

  always_comb begin
    op  = OP_NONE;
    imm = '1;
    if (cmd_rd) begin
      op  = OP_IMM;
      imm = cmd_rb;
    end else if (dat_wr) begin
      unique case (cmd[1:0])
        CODE_WRITE: op = OP_DWR;
        CODE_ADDR:  op = OP_AWR;
        default:    op = OP_NONE;
      endcase
    end else if (dat_rd) begin
      if (port_sel)                     op = OP_RPRT;
      else if (stat_sel)                op = OP_RSTA;
      else if (cmd[1:0] == CODE_READ)   op = OP_RDAT;
      else                              op = OP_IMM;
    end
  end
endmodule

// File: rtl/sndbus_bridge.sv
module sndbus_bridge
  import sndbus_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter bit EXT_CMD = 1'b1,
  localparam int CW = EXT_CMD ? 4 : 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_cmd_wr,
  input  logic          host_cmd_rd,
  input  logic          host_dat_wr,
  input  logic          host_dat_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rvalid,
  output logic          chip_addr_wr,
  output logic          chip_data_wr,
  output logic [DW-1:0] chip_wdata,
  output logic [AW-1:0] chip_addr,
  output logic          chip_rd,
  output logic [1:0]    chip_rsel,
  input  logic [DW-1:0] chip_rdata,
  output logic [DW-1:0] shadow_data
);
  logic [3:0]    cmd_val;
  logic [DW-1:0] cmd_rb;
  op_e           dec_op;
  logic [DW-1:0] dec_imm;

  sndbus_cmdreg #(.CW(CW), .DW(DW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(host_cmd_wr), .wdata(host_wdata),
    .cmd(cmd_val), .readback(cmd_rb)
  );

  sndbus_decode #(.DW(DW), .EXT_CMD(EXT_CMD)) u_dec (
    .cmd(cmd_val), .cmd_rb(cmd_rb), .cmd_rd(host_cmd_rd),
    .dat_wr(host_dat_wr), .dat_rd(host_dat_rd), .op(dec_op), .imm(dec_imm)
  );

  // Stage 1: one registered access, drives the chip side
  op_e           s1_op_d, s1_op_q;
  logic [DW-1:0] s1_imm_d, s1_imm_q;
  logic [DW-1:0] s1_wd_d, s1_wd_q;
  logic [AW-1:0] addr_d, addr_q;
  // Stage 2: read result and shadow
  logic [DW-1:0] rdata_d, rdata_q;
  logic          rvalid_d, rvalid_q;
  logic [DW-1:0] shadow_d, shadow_q;
  logic          s1_chip_rd, s1_is_read;

  always_comb begin
    s1_op_d  = dec_op;
    s1_imm_d = dec_imm;
    s1_wd_d  = s1_wd_q;
    addr_d   = addr_q;
    if (dec_op == OP_DWR || dec_op == OP_AWR) s1_wd_d = host_wdata;
    if (dec_op == OP_AWR) addr_d = host_wdata[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op_q  <= OP_NONE;
      s1_imm_q <= '0;
      s1_wd_q  <= '0;
      addr_q   <= '0;
    end else begin
      s1_op_q  <= s1_op_d;
      s1_imm_q <= s1_imm_d;
      s1_wd_q  <= s1_wd_d;
      addr_q   <= addr_d;
    end
  end

  assign s1_chip_rd = (s1_op_q == OP_RDAT) || (s1_op_q == OP_RSTA) ||
                      (s1_op_q == OP_RPRT);
  assign s1_is_read = s1_chip_rd || (s1_op_q == OP_IMM);

  always_comb begin
    unique case (s1_op_q)
      OP_RSTA: chip_rsel = SEL_STAT;
      OP_RPRT: chip_rsel = SEL_PORT;
      default: chip_rsel = SEL_DATA;
    endcase
  end

  always_comb begin
    rvalid_d = s1_is_read;
    rdata_d  = rdata_q;
    shadow_d = shadow_q;
    if (s1_is_read) rdata_d = s1_chip_rd ? chip_rdata : s1_imm_q;
    if (s1_op_q == OP_RDAT) shadow_d = chip_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      shadow_q <= '0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
      shadow_q <= shadow_d;
    end
  end

  assign chip_data_wr = (s1_op_q == OP_DWR);
  assign chip_addr_wr = (s1_op_q == OP_AWR);
  assign chip_rd      = s1_chip_rd;
  assign chip_wdata   = s1_wd_q;
  assign chip_addr    = addr_q;
  assign host_rdata   = rdata_q;
  assign host_rvalid  = rvalid_q;
  assign shadow_data  = shadow_q;
endmodule

// File: rtl/sndbus_bridge_chk.sv
module sndbus_bridge_chk #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter bit EXT_CMD = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_cmd_wr,
  input logic          host_cmd_rd,
  input logic          host_dat_wr,
  input logic          host_dat_rd,
  input logic [DW-1:0] host_wdata,
  input logic [DW-1:0] host_rdata,
  input logic          host_rvalid,
  input logic          chip_addr_wr,
  input logic          chip_data_wr,
  input logic [DW-1:0] chip_wdata,
  input logic [AW-1:0] chip_addr,
  input logic          chip_rd,
  input logic [1:0]    chip_rsel,
  input logic [DW-1:0] chip_rdata,
  input logic [DW-1:0] shadow_data,
  input logic [3:0]    cmd
);
  // Input assumption: one host strobe per cycle
  a_r9_host_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_cmd_wr, host_cmd_rd, host_dat_wr, host_dat_rd}));

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chip_addr_wr, chip_data_wr, chip_rd}));

  a_r2_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
    host_cmd_rd |-> ##2 (host_rvalid && host_rdata[DW-1:4] == '1));

  a_r3_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (host_dat_wr && cmd[1] == 1'b0) |=> (!chip_addr_wr && !chip_data_wr));

  a_r4_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    (host_dat_wr && cmd[1:0] == 2'd2) |=>
      (chip_data_wr && chip_wdata == $past(host_wdata)));

  a_r5_addr_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (host_dat_wr && cmd[1:0] == 2'd3) |=>
      (chip_addr_wr && chip_addr == $past(host_wdata[AW-1:0])));

  a_r6_conflict_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (host_dat_rd && cmd == 4'd2) |=> !chip_rd);

  a_r6_conflict_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (host_dat_rd && cmd == 4'd2) |-> ##2 (host_rvalid && host_rdata == 8'hFF));

  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_rd && chip_rsel == 2'd0) |=>
      (host_rvalid && host_rdata == $past(chip_rdata) &&
       shadow_data == $past(chip_rdata)));

  a_r8_port_first: assert property (@(posedge clk) disable iff (!rst_n)
    (EXT_CMD && host_dat_rd && cmd[3]) |=> (chip_rd && chip_rsel == 2'd2));

  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rd |=> !chip_rd);
endmodule

bind sndbus_bridge sndbus_bridge_chk #(.DW(DW), .AW(AW), .EXT_CMD(EXT_CMD)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_cmd_wr(host_cmd_wr), .host_cmd_rd(host_cmd_rd),
  .host_dat_wr(host_dat_wr), .host_dat_rd(host_dat_rd), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .host_rvalid(host_rvalid), .chip_addr_wr(chip_addr_wr),
  .chip_data_wr(chip_data_wr), .chip_wdata(chip_wdata), .chip_addr(chip_addr),
  .chip_rd(chip_rd), .chip_rsel(chip_rsel), .chip_rdata(chip_rdata),
  .shadow_data(shadow_data), .cmd(cmd_val)
);

// File: tb/sim_sndbus_bridge.sv
module sim_sndbus_bridge;
  logic       clk, rst_n;
  logic       host_cmd_wr, host_cmd_rd, host_dat_wr, host_dat_rd;
  logic [7:0] host_wdata, host_rdata, chip_wdata, chip_rdata, shadow_data;
  logic       host_rvalid, chip_addr_wr, chip_data_wr, chip_rd;
  logic [3:0] chip_addr;
  logic [1:0] chip_rsel;

  logic [7:0] m_dreg, m_stat, m_port;
  logic [3:0] m_cmd;
  int cyc, checks, errors;
  bit done;

  typedef enum int {EV_DWR, EV_AWR, EV_RD, EV_RES} ev_e;
  typedef struct {
    ev_e        kind;
    logic [7:0] val;
    int         at;
    string      req;
  } item_t;
  item_t sb[$];

  sndbus_bridge u0 (
    .clk(clk), .rst_n(rst_n), .host_cmd_wr(host_cmd_wr), .host_cmd_rd(host_cmd_rd),
    .host_dat_wr(host_dat_wr), .host_dat_rd(host_dat_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .chip_addr_wr(chip_addr_wr),
    .chip_data_wr(chip_data_wr), .chip_wdata(chip_wdata), .chip_addr(chip_addr),
    .chip_rd(chip_rd), .chip_rsel(chip_rsel), .chip_rdata(chip_rdata),
    .shadow_data(shadow_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // generator model: read bus chosen by chip_rsel
  assign chip_rdata = (chip_rsel == 2'd2) ? m_port :
                      (chip_rsel == 2'd1) ? m_stat : m_dreg;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input ev_e k, input logic [7:0] v, input int at, input string req);
    item_t it;
    it.kind = k; it.val = v; it.at = at; it.req = req;
    sb.push_back(it);
  endtask

  task automatic expect_event(input ev_e k, input logic [7:0] v, input string tag);
    item_t it;
    checks++;
    if (sb.size() == 0) begin
      errors++;
      $display("FAIL unexpected event kind=%0d actual=%h expected=none", k, v);
    end else begin
      it = sb.pop_front();
      if (it.kind != k || it.val !== v || it.at != cyc) begin
        errors++;
        $display("FAIL %s %s actual=%0d/%h@%0d expected=%0d/%h@%0d",
                 it.req, tag, k, v, cyc, it.kind, it.val, it.at);
      end
    end
  endtask

  // monitor: older read result first, then chip strobes
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (host_rvalid)  expect_event(EV_RES, host_rdata, "result");
      if (chip_data_wr) expect_event(EV_DWR, chip_wdata, "data_wr");
      if (chip_addr_wr) expect_event(EV_AWR, {4'h0, chip_addr}, "addr_wr");
      if (chip_rd)      expect_event(EV_RD, {6'h0, chip_rsel}, "chip_rd");
    end
  end

  task automatic finish_op(input string req);
    @(negedge clk);
    host_cmd_wr = 0; host_cmd_rd = 0; host_dat_wr = 0; host_dat_rd = 0;
    repeat (3) @(negedge clk);
    check({req, " drained"}, 8'(sb.size()), 8'd0);
    sb.delete();
  endtask

  task automatic wr_cmd(input logic [7:0] b);
    @(negedge clk);
    host_wdata = b; host_cmd_wr = 1;
    m_cmd = b[3:0];
    finish_op("R2");
  endtask

  task automatic rd_cmd();
    int k;
    @(negedge clk);
    k = cyc; host_cmd_rd = 1;
    push(EV_RES, {4'hF, m_cmd}, k + 2, "R2");
    finish_op("R2");
  endtask

  task automatic wr_dat(input logic [7:0] b);
    int k;
    @(negedge clk);
    k = cyc; host_wdata = b; host_dat_wr = 1;
    if (m_cmd[1:0] == 2'd2)      push(EV_DWR, b, k + 1, "R4");
    else if (m_cmd[1:0] == 2'd3) push(EV_AWR, {4'h0, b[3:0]}, k + 1, "R5");
    finish_op("R3");
  endtask

  task automatic rd_dat();
    int k;
    @(negedge clk);
    k = cyc; host_dat_rd = 1;
    if (m_cmd[3]) begin
      push(EV_RD, 8'd2, k + 1, "R8"); push(EV_RES, m_port, k + 2, "R8");
    end else if (m_cmd[2]) begin
      push(EV_RD, 8'd1, k + 1, "R8"); push(EV_RES, m_stat, k + 2, "R8");
    end else if (m_cmd[1:0] == 2'd1) begin
      push(EV_RD, 8'd0, k + 1, "R7"); push(EV_RES, m_dreg, k + 2, "R7");
    end else if (m_cmd[1:0] == 2'd2) begin
      push(EV_RES, 8'hFF, k + 2, "R6");
    end else begin
      push(EV_RES, 8'hFF, k + 2, "R3");
    end
    finish_op("R9");
  endtask

  initial begin
    cyc = 0; checks = 0; errors = 0; done = 0;
    m_cmd = 0; m_dreg = 8'h3A; m_stat = 8'h81; m_port = 8'h5E;
    host_cmd_wr = 0; host_cmd_rd = 0; host_dat_wr = 0; host_dat_rd = 0;
    host_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 strobes", {5'b0, chip_addr_wr, chip_data_wr, chip_rd}, 8'h00);
    check("R1 rvalid", {7'b0, host_rvalid}, 8'h00);
    check("R1 rdata", host_rdata, 8'h00);
    check("R1 addr", {4'h0, chip_addr}, 8'h00);
    check("R1 shadow", shadow_data, 8'h00);
    rd_cmd();                       // R1/R2: code 0 reads back F0
    // R3 idle code
    wr_dat(8'h77); rd_dat();
    // R5 address latch
    wr_cmd(8'hA3); wr_dat(8'hA7);
    check("R5 addr held", {4'h0, chip_addr}, 8'h07);
    rd_dat();                       // R3: code 3 read gives FF
    // R4 data write, R6 conflict
    wr_cmd(8'h02); wr_dat(8'h5C); wr_dat(8'hE1); rd_dat();
    check("R4 addr kept", {4'h0, chip_addr}, 8'h07);
    // R2 readback with upper bits in byte dropped
    wr_cmd(8'hF1); rd_cmd();
    // R7 read data and shadow
    wr_cmd(8'h01); rd_dat();
    check("R7 shadow", shadow_data, 8'h3A);
    m_dreg = 8'hC4; rd_dat();
    check("R7 shadow2", shadow_data, 8'hC4);
    wr_dat(8'h99);                  // R3: write under read code ignored
    check("R3 addr unchanged", {4'h0, chip_addr}, 8'h07);
    // R8 status and port priority
    wr_cmd(8'h05); rd_dat();
    wr_cmd(8'h0D); rd_dat();
    wr_cmd(8'h09); m_port = 8'h12; rd_dat();
    check("R8 shadow kept", shadow_data, 8'hC4);
    wr_cmd(8'h06); rd_dat(); wr_dat(8'h6B);
    wr_cmd(8'h0B); wr_dat(8'h3E);
    check("R8 addr via low bits", {4'h0, chip_addr}, 8'h0E);
    rd_cmd();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R9 watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule